// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge and Level Sources

This block gathers up to 32 interrupt request lines into a single request to a processor. A build-time mask marks each line as level-sensitive or edge-captured. Captured requests sit in a status word, an enable word gates them into a pending word, and a priority encoder turns the pending word into a vector: the index of the lowest-numbered pending line. When no line is pending the vector is all ones.

Software reaches the block through a plain word-wide port of eight registers. Besides direct stores to status, enable and master-enable, it has three write-only command addresses: acknowledge (clears status bits), set-enable (ORs into enable) and clear-enable (clears enable bits). These let software change single bits without a read-modify-write. The master-enable word has two control bits. Bit 1 turns on capture of the input lines. Bit 0 releases the output. The output can only rise when both bits are set.

Top module: `intc_vectored`

## Requirements
- R1: Byte address bits [4:2] select the register: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master-enable. Writes to status, enable and master-enable store the full 32-bit data, and reads return it. Reads of addresses 3, 4 and 5 return zero. Writes to the pending and vector addresses leave no lasting effect. A write whose address bits [1:0] are not zero changes nothing.
- R2: The pending word equals status AND enable. It is updated in the same clock edge as the status and enable registers.
- R3: The vector reads the index of the lowest set pending bit, zero-extended to 32 bits. With no pending bit it reads 0xFFFFFFFF.
- R4: The output is high only when master-enable bits 0 and 1 are both set and the pending word is nonzero.
- R5: A write to the acknowledge address clears each status bit whose data bit is 1. Other bits are left as they are.
- R6: A write to set-enable ORs the data into enable. A write to clear-enable clears the enable bits where the data is 1.
- R7: While master-enable bit 1 is clear, the input lines do not change the status register and the output stays low.
- R8: While capture is on, the status bit of a level-sensitive line equals the line value sampled at the previous clock edge. This holds even when an acknowledge or status write targets that bit.
- R9: While capture is on, an edge-captured line sets its status bit when the line is 1 at a clock edge after being 0 at the edge before. The bit stays set after the line drops, until it is acknowledged or written. A rising edge in the same cycle as an acknowledge of that bit leaves the bit set. Edges that occur while capture is off are never captured later.
- R10: After reset, status, pending, enable and master-enable read zero, the vector reads 0xFFFFFFFF, and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Interrupt request lines |
| busWrEn | input | 1 | Write strobe for one clock |
| busAddr | input | 5 | Byte address of the register |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr, combinational |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
Each fault in a stored register becomes visible on the next read of that register. It also reaches the pending word and the vector within the same cycle. A stale pending word or a wrong priority choice shows up directly as a vector that is not the lowest enabled status bit. It can also show up as an output high while the vector reads all ones. Capture faults are observable one clock after the input changes, through three symptoms. A level bit that does not follow its line reveals one. An edge bit that drops without an acknowledge reveals another. The third is a bit set while capture was off.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_LSB = 2;
  localparam int MASTER_OUT_BIT = 0;
  localparam int MASTER_CAP_BIT = 1;

  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_PEND   = 3'd1,
    REG_ENABLE = 3'd2,
    REG_ACK    = 3'd3,
    REG_SETEN  = 3'd4,
    REG_CLREN  = 3'd5,
    REG_VECTOR = 3'd6,
    REG_MASTER = 3'd7
  } regIdxE;

  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrAck;
    logic wrSetEn;
    logic wrClrEn;
    logic wrMaster;
  } ctrlStrobeS;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobeS        strb,
  output regIdxE            rdIdx
);
  logic aligned;
  logic wrOk;

  assign rdIdx   = regIdxE'(busAddr[ADDR_W-1:WORD_LSB]);
  assign aligned = (busAddr[WORD_LSB-1:0] == '0);
  assign wrOk    = busWrEn && aligned;

  always_comb begin
    strb = '0;
    if (wrOk) begin
      unique case (rdIdx)
        REG_STATUS: strb.wrStatus = 1'b1;
        REG_ENABLE: strb.wrEnable = 1'b1;
        REG_ACK:    strb.wrAck    = 1'b1;
        REG_SETEN:  strb.wrSetEn  = 1'b1;
        REG_CLREN:  strb.wrClrEn  = 1'b1;
        REG_MASTER: strb.wrMaster = 1'b1;
        default:    strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_SRC-1:0] pending,
  output logic [DATA_W-1:0]  vector
);
  always_comb begin
    vector = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) vector = DATA_W'(i);
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,
  parameter int                 DATA_W    = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  ctrlStrobeS         strb,
  input  regIdxE             rdIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  vectorIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [NUM_SRC-1:0] pendingQ,
  output logic [DATA_W-1:0]  masterQ
);
  localparam logic [NUM_SRC-1:0] LEVEL_MASK = ~EDGE_MASK;

  logic [NUM_SRC-1:0] srcPrevQ;
  logic [NUM_SRC-1:0] dataSrc;
  logic [NUM_SRC-1:0] baseStatus;
  logic [NUM_SRC-1:0] nextStatus;
  logic [NUM_SRC-1:0] nextEnable;
  logic [NUM_SRC-1:0] riseVec;
  logic               captureOn;

  assign dataSrc   = wrData[NUM_SRC-1:0];
  assign captureOn = masterQ[MASTER_CAP_BIT];
  assign riseVec   = srcIn & ~srcPrevQ;

  always_comb begin
    baseStatus = strb.wrStatus ? dataSrc : statusQ;
    if (strb.wrAck) baseStatus = baseStatus & ~dataSrc;
    if (captureOn) begin
      nextStatus = ((baseStatus | riseVec) & EDGE_MASK) | (srcIn & LEVEL_MASK);
    end else begin
      nextStatus = baseStatus;
    end
  end

  always_comb begin
    nextEnable = strb.wrEnable ? dataSrc : enableQ;
    if (strb.wrSetEn) nextEnable = nextEnable | dataSrc;
    if (strb.wrClrEn) nextEnable = nextEnable & ~dataSrc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ  <= '0;
      enableQ  <= '0;
      pendingQ <= '0;
      masterQ  <= '0;
      srcPrevQ <= '0;
    end else begin
      statusQ  <= nextStatus;
      enableQ  <= nextEnable;
      pendingQ <= nextStatus & nextEnable;
      srcPrevQ <= srcIn;
      if (strb.wrMaster) masterQ <= wrData;
    end
  end

  always_comb begin
    unique case (rdIdx)
      REG_STATUS: rdData = DATA_W'(statusQ);
      REG_PEND:   rdData = DATA_W'(pendingQ);
      REG_ENABLE: rdData = DATA_W'(enableQ);
      REG_VECTOR: rdData = vectorIn;
      REG_MASTER: rdData = masterQ;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,
  parameter int                 DATA_W    = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut
);
  ctrlStrobeS         strb;
  regIdxE             rdIdx;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] pendingQ;
  logic [DATA_W-1:0]  masterQ;
  logic [DATA_W-1:0]  vectorQ;

  intc_ctrl u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strb    (strb),
    .rdIdx   (rdIdx)
  );

  intc_prio #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_prio (
    .pending (pendingQ),
    .vector  (vectorQ)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .EDGE_MASK(EDGE_MASK)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .srcIn    (srcIn),
    .strb     (strb),
    .rdIdx    (rdIdx),
    .wrData   (busWrData),
    .vectorIn (vectorQ),
    .rdData   (busRdData),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .pendingQ (pendingQ),
    .masterQ  (masterQ)
  );

  assign irqOut = masterQ[MASTER_OUT_BIT] && masterQ[MASTER_CAP_BIT] && (pendingQ != '0);
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busWrEn,
  input logic [4:0]         busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic [NUM_SRC-1:0] pendingQ,
  input logic [DATA_W-1:0]  masterQ,
  input logic [DATA_W-1:0]  vectorQ
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0]   vecIdx;
  logic [NUM_SRC-1:0] belowMask;
  logic               ackWr;
  logic               setWr;

  assign vecIdx    = vectorQ[IDX_W-1:0];
  assign belowMask = (NUM_SRC'(1) << vecIdx) - NUM_SRC'(1);
  assign ackWr     = busWrEn && busAddr == 5'h0C;
  assign setWr     = busWrEn && busAddr == 5'h10;

  AST_PEND_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
    pendingQ == (statusQ & enableQ)); // R2
  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (pendingQ != '0) |-> (pendingQ[vecIdx] && (pendingQ & belowMask) == '0)); // R3
  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pendingQ == '0) |-> (vectorQ == '1)); // R3
  AST_IRQ_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (vectorQ != '1)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ackWr && !masterQ[1]) |=> ((statusQ & $past(busWrData[NUM_SRC-1:0])) == '0)); // R5
  AST_SETEN_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    setWr |=> ((enableQ & $past(busWrData[NUM_SRC-1:0])) == $past(busWrData[NUM_SRC-1:0]))); // R6
  AST_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busWrEn && !masterQ[1]) |=> $stable(statusQ)); // R7
endmodule

bind intc_vectored intc_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .irqOut    (irqOut),
  .statusQ   (statusQ),
  .enableQ   (enableQ),
  .pendingQ  (pendingQ),
  .masterQ   (masterQ),
  .vectorQ   (vectorQ)
);

// File: tb/intc_vectored_bench.sv
`timescale 1ns/1ps
module intc_vectored_bench;
  localparam int NS = 32;
  localparam logic [31:0] EDGES = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] srcIn = '0;
  logic        busWrEn = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intc_vectored #(.NUM_SRC(NS), .DATA_W(32), .EDGE_MASK(EDGES)) u_intc_vectored (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = {idx[2:0], lo}; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    busAddr = {idx[2:0], 2'b00};
    #1 d = busRdData;
  endtask

  function automatic logic [31:0] lowest(input logic [31:0] p);
    if (p == 0) return 32'hFFFF_FFFF;
    for (int k = 0; k < 32; k++) if (p[k]) return k;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic rdChk(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    #1 check("R10 irq", {31'b0, irqOut}, 0);
    rdChk("R10 status", 0, 0);
    rdChk("R10 pending", 1, 0);
    rdChk("R10 enable", 2, 0);
    rdChk("R10 vector", 6, 32'hFFFF_FFFF);
    rdChk("R10 master", 7, 0);
    // R1 register map
    wr(2, 32'hA5A5_0F0F);
    rdChk("R1 enable store", 2, 32'hA5A5_0F0F);
    wr(0, 32'h1234_5678);
    rdChk("R1 status store", 0, 32'h1234_5678);
    wr(7, 32'hC0DE_0000);
    rdChk("R1 master store", 7, 32'hC0DE_0000);
    wr(7, 0);
    wr(1, 32'hFFFF_FFFF);
    rdChk("R1 pending write ignored", 1, 32'h1234_5678 & 32'hA5A5_0F0F);
    wr(6, 0);
    rdChk("R1 vector write ignored", 6, lowest(32'h1234_5678 & 32'hA5A5_0F0F));
    rdChk("R1 ack reads zero", 3, 0);
    rdChk("R1 seten reads zero", 4, 0);
    rdChk("R1 clren reads zero", 5, 0);
    wr(0, 32'hFFFF_FFFF, 2'b10);
    rdChk("R1 misaligned write ignored", 0, 32'h1234_5678);
    // R5 acknowledge
    wr(3, 32'h0000_0F00);
    rdChk("R5 ack clears", 0, 32'h1234_5078);
    // R6 set / clear enable
    wr(5, 32'hFFFF_FFFF);
    rdChk("R6 clear all", 2, 0);
    wr(4, 32'h0000_00F0);
    rdChk("R6 set first", 2, 32'h0000_00F0);
    wr(4, 32'h0000_0F00);
    rdChk("R6 set ors", 2, 32'h0000_0FF0);
    wr(5, 32'h0000_0030);
    rdChk("R6 clear selected", 2, 32'h0000_0FC0);
    // R2 / R3 sweep, capture off
    wr(4, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      pat = ((32'h9E37_79B9 * (i + 1)) | 32'h1) << i;
      wr(0, pat);
      rdChk($sformatf("R3 vector sweep %0d", i), 6, i);
      rdChk($sformatf("R2 pending sweep %0d", i), 1, pat);
    end
    wr(0, 0);
    rdChk("R3 vector empty", 6, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    wr(2, 32'hAAAA_AAAA);
    rdChk("R2 pending masked", 1, 32'hAAAA_AAAA);
    rdChk("R3 vector masked", 6, 1);
    wr(2, 32'hFFFF_FFFF);
    // R4 / R7 output gating
    wr(0, 32'h8000_0001);
    wr(7, 1);
    #1 check("R7 out low without capture", {31'b0, irqOut}, 0);
    wr(7, 3);
    rdChk("R8 level bits follow low inputs", 0, 32'h8000_0000);
    check("R4 irq high", {31'b0, irqOut}, 1);
    rdChk("R3 vector 31", 6, 31);
    wr(5, 32'h8000_0000);
    #1 check("R4 irq low when nothing enabled", {31'b0, irqOut}, 0);
    wr(4, 32'h8000_0000);
    wr(7, 2);
    #1 check("R4 irq low without out bit", {31'b0, irqOut}, 0);
    // R8 level tracking
    wr(7, 3);
    wr(3, 32'hFFFF_FFFF);
    rdChk("R5 ack all", 0, 0);
    @(negedge clk); srcIn[5] = 1'b1;
    rdChk("R8 level set", 0, 32'h0000_0020);
    check("R4 irq level", {31'b0, irqOut}, 1);
    rdChk("R3 vector level", 6, 5);
    wr(3, 32'h0000_0020);
    rdChk("R8 ack loses to level", 0, 32'h0000_0020);
    @(negedge clk); srcIn[5] = 1'b0;
    rdChk("R8 level clear", 0, 0);
    #1 check("R4 irq drops", {31'b0, irqOut}, 0);
    // R9 edge capture
    @(negedge clk); srcIn[20] = 1'b1;
    rdChk("R9 edge set", 0, 32'h0010_0000);
    @(negedge clk); srcIn[20] = 1'b0;
    rdChk("R9 edge held", 0, 32'h0010_0000);
    wr(3, 32'h0010_0000);
    rdChk("R9 ack clears edge", 0, 0);
    @(negedge clk);
    srcIn[20] = 1'b1; busWrEn = 1'b1; busAddr = 5'h0C; busWrData = 32'h0010_0000;
    @(negedge clk); busWrEn = 1'b0;
    rdChk("R9 edge beats ack", 0, 32'h0010_0000);
    wr(3, 32'h0010_0000);
    rdChk("R9 held high no new edge", 0, 0);
    @(negedge clk); srcIn[20] = 1'b0;
    // R7 capture off
    wr(7, 1);
    @(negedge clk); srcIn[3] = 1'b1; srcIn[25] = 1'b1;
    repeat (2) @(negedge clk);
    rdChk("R7 no capture", 0, 0);
    #1 check("R7 irq low", {31'b0, irqOut}, 0);
    wr(7, 3);
    rdChk("R9 missed edge not captured", 0, 32'h0000_0008);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule